// File: doc/BRIEF.md
# Set-wise Rank Ray Attack Unit

This unit produces, in a single combinational pass followed by one output register, the union of ray attacks along ranks for every sliding piece on a board at once. The board is a flat word of `RANKS` groups of `FILES` bits, one group per rank. Bit `r*FILES + f` is the square in rank `r`, file `f`. A caller presents an occupancy word, a slider word and a direction. One cycle later the unit returns the set of squares the sliders reach along their own ranks, up to and including the first occupied square.

The unit uses a single board-wide subtraction. A constant fence column, file 0 of every rank, is ORed into the occupancy before the subtraction. A borrow that runs off the top of one rank is then absorbed by the fence of the next rank, and cannot flood the empty ranks above it. Twice the slider word is subtracted from the fenced occupancy. The difference is XORed with the occupancy, and the fence column is cleared from the result. The opposite direction reuses the same datapath, with the file order inside each rank mirrored on the way in and on the way out.

The slider word is expected to be a subset of the occupancy. If a slider square is not occupied, the output for that input is unspecified.

Top module: `rank_atk_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and every bit of `out_attacks` become 0.
- R2: `out_valid` at a clock edge equals the `in_valid` sampled at the previous edge, so results appear exactly one cycle after the request.
- R3: With `in_dir` = 0 (toward higher file index), a bit `(r,g)` of the result is 1 exactly when some slider `(r,f)` has `f < g` and no occupied square lies strictly between files `f` and `g` of rank `r`. The first occupied square is therefore included.
- R4: With `in_dir` = 1 (toward lower file index), the same rule holds with `g < f`.
- R5: Attacks never cross a rank boundary. A rank with no slider yields all zeros. File 0 is never set for `in_dir` = 0, and file `FILES-1` is never set for `in_dir` = 1, whatever the lower ranks hold.
- R6: When one rank holds several sliders, the result for that rank is the union of each slider's individual ray.
- R7: When `in_valid` is low, `out_attacks` keeps its previous value and the input words have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_dir | input | 1 | Ray direction: 0 toward higher file index, 1 toward lower file index |
| in_occ | input | FILES*RANKS | Occupied squares, sliders included |
| in_sliders | input | FILES*RANKS | Squares holding a sliding piece |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_attacks | output | FILES*RANKS | Union of rank attacks for all sliders |

## Verification
The bench builds one instance with `FILES` = 4 and `RANKS` = 2. That is small enough to apply every occupancy together with every slider subset of it, in both directions: 6561 boards, which include every blocker order, adjacent sliders and a borrow leaving the top file of rank 0. A second instance at the default 8×8 size takes random sparse boards and directed cases: a lone slider beside empty upper ranks, a slider in the top corner square, and several sliders sharing a rank. Both instances are checked against a square-by-square ray walk computed in the bench.

// File: rtl/rank_atk_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the rank attack unit.
// Assumes nothing beyond being compiled before the modules that import it.
package rank_atk_pkg;

    // Ray direction along a rank, as carried on the in_dir pin.
    typedef enum logic {
        RAY_UP_FILE   = 1'b0,   // toward higher file index
        RAY_DOWN_FILE = 1'b1    // toward lower file index
    } ray_dir_e;

endpackage

// File: rtl/rank_mirror.sv
`timescale 1ns/1ps
// Module: rank_mirror
// Reverses the order of the files inside every rank when en is high and
// passes the word through unchanged otherwise. Purely combinational.
// Assumes the word is RANKS groups of FILES bits, rank 0 in the low bits.
module rank_mirror #(
    parameter int FILES = 8,
    parameter int RANKS = 8
) (
    input  logic                     en,
    input  logic [FILES*RANKS-1:0]   din,
    output logic [FILES*RANKS-1:0]   dout
);
    localparam int W = FILES * RANKS;

    logic [W-1:0] flipped;

    // Build the mirrored word one square at a time.
    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        for (genvar f = 0; f < FILES; f++) begin : g_file
            assign flipped[r*FILES + f] = din[r*FILES + (FILES - 1 - f)];
        end
    end

    // Pick the mirrored or the straight word.
    always_comb begin
        dout = en ? flipped : din;
    end
endmodule

// File: rtl/rank_borrow_core.sv
`timescale 1ns/1ps
// Module: rank_borrow_core
// Computes upward-file rank attacks for all sliders with one subtraction.
// File 0 of every rank is forced occupied so a borrow leaving a rank is
// absorbed there instead of rippling into the ranks above.
// Assumes sliders is a subset of occ; otherwise the result is unspecified.
module rank_borrow_core #(
    parameter int FILES = 8,
    parameter int RANKS = 8
) (
    input  logic [FILES*RANKS-1:0] occ,
    input  logic [FILES*RANKS-1:0] sliders,
    output logic [FILES*RANKS-1:0] attacks
);
    localparam int W = FILES * RANKS;

    logic [W-1:0] fence;
    logic [W-1:0] fenced_occ;
    logic [W-1:0] shifted_sl;
    logic [W-1:0] diff;

    // Fence column: lowest file of every rank.
    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        for (genvar f = 0; f < FILES; f++) begin : g_file
            assign fence[r*FILES + f] = (f == 0);
        end
    end

    // Subtract twice the sliders from the fenced occupancy and keep the changed bits.
    always_comb begin
        fenced_occ = occ | fence;
        shifted_sl = sliders << 1;
        diff       = fenced_occ - shifted_sl;
        attacks    = (diff ^ occ) & ~fence;
    end
endmodule

// File: rtl/rank_atk_outreg.sv
`timescale 1ns/1ps
// Module: rank_atk_outreg
// Output stage: captures the result word on a request and carries the
// strobe one cycle. The word holds its value while no request is present.
// Assumes a synchronous, active-low reset.
module rank_atk_outreg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_valid,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);
    // Strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= d_valid;
    end

    // Result register, loaded only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (d_valid) q <= d;
    end
endmodule

// File: rtl/rank_atk_unit.sv
`timescale 1ns/1ps
// Module: rank_atk_unit (top)
// Set-wise rank attack generator. Mirrors the files of each rank for the
// downward direction, runs the shared borrow core, mirrors back and
// registers the result together with a valid strobe.
// Assumes in_sliders is a subset of in_occ on every request.
module rank_atk_unit
    import rank_atk_pkg::*;
#(
    parameter int FILES = 8,
    parameter int RANKS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_dir,
    input  logic [FILES*RANKS-1:0] in_occ,
    input  logic [FILES*RANKS-1:0] in_sliders,
    output logic                   out_valid,
    output logic [FILES*RANKS-1:0] out_attacks
);
    localparam int W = FILES * RANKS;

    logic         flip;
    logic [W-1:0] occ_m;
    logic [W-1:0] sl_m;
    logic [W-1:0] atk_m;
    logic [W-1:0] atk;

    // Decode the direction pin.
    always_comb begin
        flip = (ray_dir_e'(in_dir) == RAY_DOWN_FILE);
    end

    rank_mirror #(.FILES(FILES), .RANKS(RANKS)) u_mir_occ (
        .en(flip), .din(in_occ), .dout(occ_m)
    );

    rank_mirror #(.FILES(FILES), .RANKS(RANKS)) u_mir_sl (
        .en(flip), .din(in_sliders), .dout(sl_m)
    );

    rank_borrow_core #(.FILES(FILES), .RANKS(RANKS)) u_core (
        .occ(occ_m), .sliders(sl_m), .attacks(atk_m)
    );

    rank_mirror #(.FILES(FILES), .RANKS(RANKS)) u_mir_out (
        .en(flip), .din(atk_m), .dout(atk)
    );

    rank_atk_outreg #(.W(W)) u_oreg (
        .clk(clk), .rst_n(rst_n), .d_valid(in_valid), .d(atk),
        .q_valid(out_valid), .q(out_attacks)
    );
endmodule

// File: rtl/rank_atk_unit_chk.sv
`timescale 1ns/1ps
// Module: rank_atk_unit_chk
// Property checker for rank_atk_unit, attached by bind below. Keeps its
// own copy of the last accepted request to relate inputs to outputs.
module rank_atk_unit_chk #(
    parameter int FILES = 8,
    parameter int RANKS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_dir,
    input logic [FILES*RANKS-1:0] in_occ,
    input logic [FILES*RANKS-1:0] in_sliders,
    input logic                   out_valid,
    input logic [FILES*RANKS-1:0] out_attacks
);
    localparam int W = FILES * RANKS;

    logic [W-1:0] low_col;
    logic [W-1:0] high_col;
    logic [W-1:0] p_occ;
    logic [W-1:0] p_sl;
    logic         p_dir;
    logic         subset_ok;

    for (genvar r = 0; r < RANKS; r++) begin : g_col
        for (genvar f = 0; f < FILES; f++) begin : g_f
            assign low_col[r*FILES + f]  = (f == 0);
            assign high_col[r*FILES + f] = (f == FILES - 1);
        end
    end

    assign subset_ok = ((in_sliders & ~in_occ) == '0);

    // Remember the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_occ <= '0;
            p_sl  <= '0;
            p_dir <= 1'b0;
        end else if (in_valid) begin
            p_occ <= in_occ;
            p_sl  <= in_sliders;
            p_dir <= in_dir;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_attacks));  // R7
    AST_UP_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dir && subset_ok) |=> ((out_attacks & low_col) == '0));  // R5
    AST_DOWN_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dir && subset_ok) |=> ((out_attacks & high_col) == '0));  // R5

    for (genvar r = 0; r < RANKS; r++) begin : g_rank_chk
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && subset_ok && in_sliders[r*FILES +: FILES] == '0)
            |=> (out_attacks[r*FILES +: FILES] == '0));  // R5
        for (genvar f = 0; f < FILES; f++) begin : g_sq
            if (f > 0) begin : g_up
                AST_UP_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && !p_dir && ((p_sl & ~p_occ) == '0) && out_attacks[r*FILES + f])
                    |-> (p_sl[r*FILES + f - 1] ||
                         (out_attacks[r*FILES + f - 1] && !p_occ[r*FILES + f - 1])));  // R3
            end
            if (f < FILES - 1) begin : g_dn
                AST_DOWN_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && p_dir && ((p_sl & ~p_occ) == '0) && out_attacks[r*FILES + f])
                    |-> (p_sl[r*FILES + f + 1] ||
                         (out_attacks[r*FILES + f + 1] && !p_occ[r*FILES + f + 1])));  // R4
            end
        end
    end
endmodule

bind rank_atk_unit rank_atk_unit_chk #(.FILES(FILES), .RANKS(RANKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dir(in_dir),
    .in_occ(in_occ), .in_sliders(in_sliders),
    .out_valid(out_valid), .out_attacks(out_attacks)
);

// File: tb/rank_atk_unit_tb.sv
`timescale 1ns/1ps
module rank_atk_unit_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        s_valid, s_dir;
    logic [7:0]  s_occ, s_sl, s_oa;
    logic        s_ov;
    logic        b_valid, b_dir;
    logic [63:0] b_occ, b_sl, b_oa;
    logic        b_ov;
    int checks = 0;
    int errors = 0;

    rank_atk_unit #(.FILES(4), .RANKS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_dir(s_dir),
        .in_occ(s_occ), .in_sliders(s_sl), .out_valid(s_ov), .out_attacks(s_oa)
    );

    rank_atk_unit #(.FILES(8), .RANKS(8)) u_dut_full (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_dir(b_dir),
        .in_occ(b_occ), .in_sliders(b_sl), .out_valid(b_ov), .out_attacks(b_oa)
    );

    // Square-by-square ray walk.
    function automatic logic [63:0] walk(input logic [63:0] occ, input logic [63:0] sl,
                                         input int files, input int ranks, input bit dir);
        logic [63:0] res;
        res = '0;
        for (int r = 0; r < ranks; r++) begin
            for (int f = 0; f < files; f++) begin
                if (sl[r*files + f]) begin
                    if (!dir) begin
                        for (int g = f + 1; g < files; g++) begin
                            res[r*files + g] = 1'b1;
                            if (occ[r*files + g]) break;
                        end
                    end else begin
                        for (int g = f - 1; g >= 0; g--) begin
                            res[r*files + g] = 1'b1;
                            if (occ[r*files + g]) break;
                        end
                    end
                end
            end
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic big(input logic v, input logic d, input logic [63:0] o, input logic [63:0] s);
        b_valid = v; b_dir = d; b_occ = o; b_sl = s;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        rst_n = 1'b0;
        s_valid = 0; s_dir = 0; s_occ = 8'hFF; s_sl = 8'h11;
        b_valid = 0; b_dir = 0; b_occ = '1; b_sl = 64'h1;
        repeat (3) @(negedge clk);
        // R1: reset state of both instances
        check("R1 small valid", {63'd0, s_ov}, 64'd0);
        check("R1 small attacks", {56'd0, s_oa}, 64'd0);
        check("R1 full valid", {63'd0, b_ov}, 64'd0);
        check("R1 full attacks", b_oa, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6: every occupancy with every slider subset, both directions
        for (int o = 0; o < 256; o++) begin
            for (int s = 0; s < 256; s++) begin
                if ((s & ~o) == 0) begin
                    for (int d = 0; d < 2; d++) begin
                        s_valid = 1'b1; s_dir = d[0]; s_occ = o[7:0]; s_sl = s[7:0];
                        @(negedge clk);
                        check(d ? "R4 sweep" : "R3 sweep", {56'd0, s_oa},
                              walk({56'd0, o[7:0]}, {56'd0, s[7:0]}, 4, 2, d[0]));
                    end
                end
            end
        end
        check("R2 small valid after request", {63'd0, s_ov}, 64'd1);

        // R7: idle cycle with new inputs leaves the result untouched
        held = s_oa;
        s_valid = 1'b0; s_dir = 1'b0; s_occ = 8'h31; s_sl = 8'h01;
        @(negedge clk);
        check("R7 small hold", {56'd0, s_oa}, {56'd0, held});
        check("R2 small valid idle", {63'd0, s_ov}, 64'd0);

        // Directed cases on the full board
        big(1, 0, 64'h10, 64'h10);
        check("R5 lone slider, empty ranks above", b_oa, 64'hE0);
        check("R2 full valid", {63'd0, b_ov}, 64'd1);
        big(1, 0, 64'h80, 64'h80);
        check("R5 top file, no wrap", b_oa, 64'd0);
        big(1, 1, 64'h0100_0000_0000_0000, 64'h0100_0000_0000_0000);
        check("R5 bottom file downward", b_oa, 64'd0);
        big(1, 1, 64'h1000_0000_0000_0000, 64'h1000_0000_0000_0000);
        check("R4 corner rank downward", b_oa, 64'h0F00_0000_0000_0000);
        big(1, 0, 64'h95, 64'h11);
        check("R6 two sliders one rank", b_oa, 64'hE6);
        big(1, 1, 64'hA900, 64'h8800);
        check("R6 two sliders downward", b_oa, walk(64'hA900, 64'h8800, 8, 8, 1'b1));
        big(0, 0, 64'hFFFF, 64'h1);
        check("R7 full hold", b_oa, walk(64'hA900, 64'h8800, 8, 8, 1'b1));
        check("R2 full idle", {63'd0, b_ov}, 64'd0);

        // R3 R4: random sparse boards on the full size
        for (int i = 0; i < 2000; i++) begin
            logic [63:0] o, s;
            o = {$urandom, $urandom};
            s = o & {$urandom, $urandom} & {$urandom, $urandom};
            big(1, i[0], o, s);
            check(i[0] ? "R4 random" : "R3 random", b_oa, walk(o, s, 8, 8, i[0]));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule